// File: doc/BRIEF.md
# Quadrature Early/Late Phase Detector

This block is the digital decision stage of a clock and data recovery loop. Once per bit period it receives a word of samples from a fixed multi-phase oversampler, which spans one unit interval. Bit 0 of the word is the earliest sample. Index 0 is taken at the falling edge of the in-phase clock, which is the nominal data transition point when the loop is in lock. Index `OVS/2` is taken at the rising edge of the in-phase clock, at the bit centre. The quadrature clock supplies index `OVS/4` of the current word and index `3*OVS/4` of the previous word. These two samples sit a quarter of a unit interval after and before the nominal transition point.

On each data transition the detector tells the charge pump whether the recovered clock is late or early. The weak command is issued alone when the phase error is small. A strong command is added when a quadrature sample already disagrees with the bit centre next to it, which means the transition has moved more than about a quarter of a unit interval. The block also outputs the retimed data bit. An acquisition-mode input reduces the outputs to the single up/down pair used while the frequency loop is searching.

All outputs are registered, so the result for the word presented before a clock edge appears just after that edge.

Top module: `qbb_phase_det`

## Requirements
- R1: While `rst_n` is low, `ret_data`, `pump_up`, `pump_dn`, `pump_up_hi` and `pump_dn_hi` are all 0.
- R2: After each clock edge, `ret_data` equals sample index `OVS/2` of the word presented before that edge.
- R3: When the bit-centre sample (index `OVS/2`) of the current word equals that of the previous word, all four pump outputs are 0 after the edge.
- R4: When the bit-centre samples of the previous and current words differ, exactly one weak command is issued. If sample index 0 of the current word equals the new bit, `pump_up` (clock late) is set. Otherwise sample index 0 equals the old bit, and `pump_dn` (clock early) is set.
- R5: In tracking mode (`acq_mode` = 0), `pump_dn_hi` is set together with `pump_dn` when sample index `OVS/4` of the current word still equals the old bit.
- R6: In tracking mode, `pump_up_hi` is set together with `pump_up` when sample index `3*OVS/4` of the previous word already equals the new bit.
- R7: With `acq_mode` = 1 on the word's edge, `pump_up_hi` and `pump_dn_hi` are 0 after that edge, and the weak commands are unchanged.
- R8: `pump_up` and `pump_dn` are never both 1. A strong output is 1 only together with its matching weak output.
- R9: The first word accepted after reset produces no pump command, because there is no previous bit to compare with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, one word per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_mode | input | 1 | 1 = frequency acquisition (weak commands only), 0 = phase tracking |
| samp_word | input | OVS | Oversampled unit interval, bit 0 earliest |
| ret_data | output | 1 | Retimed data bit |
| pump_up | output | 1 | Weak up command (clock late) |
| pump_dn | output | 1 | Weak down command (clock early) |
| pump_up_hi | output | 1 | Additional strong up command |
| pump_dn_hi | output | 1 | Additional strong down command |

## Verification
The detector holds only one previous word and a primed flag. Any fault in that state shows at the ports one edge after the word that exposes it. A stale or shifted previous word flips the direction of the next command, or makes a command appear during a run without transitions. A wrong quadrature tap instead moves the phase offset at which the strong outputs start, so the bench sweeps the transition position from three samples late to three samples early. For each offset, the up/down and strong/weak pattern expected at every bit is fixed.

// File: rtl/qbb_phase_det.sv
module qbb_phase_det #(
  parameter int OVS = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           acq_mode,
  input  logic [OVS-1:0] samp_word,
  output logic           ret_data,
  output logic           pump_up,
  output logic           pump_dn,
  output logic           pump_up_hi,
  output logic           pump_dn_hi
);
  localparam int EDGE_IDX = 0;
  localparam int MID_IDX  = OVS / 2;
  localparam int QE_IDX   = OVS / 4;
  localparam int QL_IDX   = (3 * OVS) / 4;

  logic [OVS-1:0] prev_w;
  logic           primed;

  wire bit_old = prev_w[MID_IDX];
  wire bit_new = samp_word[MID_IDX];
  wire edge_s  = samp_word[EDGE_IDX];
  wire q_early = samp_word[QE_IDX];
  wire q_late  = prev_w[QL_IDX];

  wire xition  = primed && (bit_old != bit_new);
  wire clk_lat = xition && (edge_s == bit_new);
  wire clk_ear = xition && (edge_s == bit_old);
  wire big_lat = clk_lat && !acq_mode && (q_late == bit_new);
  wire big_ear = clk_ear && !acq_mode && (q_early == bit_old);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_w     <= '0;
      primed     <= 1'b0;
      ret_data   <= 1'b0;
      pump_up    <= 1'b0;
      pump_dn    <= 1'b0;
      pump_up_hi <= 1'b0;
      pump_dn_hi <= 1'b0;
    end else begin
      prev_w     <= samp_word;
      primed     <= 1'b1;
      ret_data   <= bit_new;
      pump_up    <= clk_lat;
      pump_dn    <= clk_ear;
      pump_up_hi <= big_lat;
      pump_dn_hi <= big_ear;
    end
  end

  assert_retime_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ret_data == $past(samp_word[MID_IDX]));

  assert_quiet_no_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_data == $past(ret_data)) |-> (!pump_up && !pump_dn && !pump_up_hi && !pump_dn_hi));

  assert_acq_no_strong_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acq_mode |=> (!pump_up_hi && !pump_dn_hi));

  assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pump_up, pump_dn}));

  assert_strong_needs_weak_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!pump_up_hi || pump_up) && (!pump_dn_hi || pump_dn));

  assert_first_word_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(primed) |-> (!pump_up && !pump_dn));
endmodule

// File: tb/qbb_phase_det_tb_top.sv
`timescale 1ns/1ps
module qbb_phase_det_tb_top;
  localparam int OVS = 8;
  localparam int NB  = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acq_mode = 1'b0;
  logic [OVS-1:0] samp_word = '0;
  logic ret_data, pump_up, pump_dn, pump_up_hi, pump_dn_hi;

  qbb_phase_det #(.OVS(OVS)) dut_i (
    .clk(clk), .rst_n(rst_n), .acq_mode(acq_mode), .samp_word(samp_word),
    .ret_data(ret_data), .pump_up(pump_up), .pump_dn(pump_dn),
    .pump_up_hi(pump_up_hi), .pump_dn_hi(pump_dn_hi));

  always #2 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  logic [4:0] q_exp[$];
  string      q_tag[$];
  logic bits [NB];
  int   phi  [NB];

  task automatic check(input bit ok, input string req, input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b (rd,up,dn,up_hi,dn_hi)", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  function automatic logic [OVS-1:0] mk_word(input int k);
    logic [OVS-1:0] w;
    for (int s = 0; s < OVS; s++) begin
      int t = k * OVS + s;
      logic v = bits[0];
      for (int j = 0; j <= k + 1; j++)
        if (j * OVS + phi[j] <= t) v = bits[j];
      w[s] = v;
    end
    return w;
  endfunction

  // monitor: pops one expectation per edge after the driver pushed it
  always @(posedge clk) begin
    #1;
    if (rst_n && q_exp.size() > 0) begin
      logic [4:0] e = q_exp.pop_front();
      string tg = q_tag.pop_front();
      logic [4:0] a = {ret_data, pump_up, pump_dn, pump_up_hi, pump_dn_hi};
      check(a[4] == e[4], "R2", a, e);
      check(a[3:0] == e[3:0], tg, a, e);
      check(!(a[3] && a[2]) && (!a[1] || a[3]) && (!a[0] || a[2]), "R8", a, e);
    end
  end

  task automatic run_seg(input logic acq);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check({ret_data, pump_up, pump_dn, pump_up_hi, pump_dn_hi} == 5'b0, "R1",
          {ret_data, pump_up, pump_dn, pump_up_hi, pump_dn_hi}, 5'b0);
    rst_n = 1'b1;
    for (int k = 1; k <= NB - 2; k++) begin
      logic tr, up, dn, uh, dh;
      string tg;
      samp_word = mk_word(k);
      acq_mode  = acq;
      tr = (k > 1) && (bits[k] != bits[k-1]);
      up = tr && (phi[k] <= 0);
      dn = tr && (phi[k] > 0);
      uh = up && !acq && (phi[k] <= -2);
      dh = dn && !acq && (phi[k] >= 3);
      if (k == 1) tg = "R9";
      else if (!tr) tg = "R3";
      else if (acq) tg = "R7";
      else if (uh) tg = "R6";
      else if (dh) tg = "R5";
      else tg = "R4";
      q_exp.push_back({bits[k], up, dn, uh, dh});
      q_tag.push_back(tg);
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic fill(input int pat, input int ph);
    for (int j = 0; j < NB; j++) begin
      case (pat)
        0: bits[j] = j[0];
        1: bits[j] = logic'(((j * 13 + (j >> 2) * 5) >> 1) & 1);
        default: bits[j] = logic'((j / 6) & 1);
      endcase
      phi[j] = (ph == 99) ? ((j * 5) % 7) - 3 : ph;
    end
    phi[0] = 0;
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk);
    fill(0, 0);   run_seg(1'b0);  // R4 lock dither, up
    fill(1, 1);   run_seg(1'b0);  // R4 early, dn
    fill(1, 2);   run_seg(1'b0);  // R4 no strong at quarter boundary
    fill(1, 3);   run_seg(1'b0);  // R5 strong dn
    fill(1, -1);  run_seg(1'b0);  // R4 late, up
    fill(0, -2);  run_seg(1'b0);  // R6 strong up
    fill(1, -3);  run_seg(1'b0);  // R6 strong up
    fill(2, 99);  run_seg(1'b0);  // R3 long runs with jitter
    fill(1, 99);  run_seg(1'b0);  // R5 R6 mixed jitter
    fill(0, 3);   run_seg(1'b1);  // R7 acquisition
    fill(1, 99);  run_seg(1'b1);  // R7 acquisition with jitter
    finish_run();
  end
endmodule